// File: doc/BRIEF.md
# Banked Memory and Port Address Decoder

This block steers every data-side load and store of a 16-bit processor to the right target. Each cycle it looks at the request address, the read and write strobes and two bits of the settings register. The bank bit picks which RAM sits behind the middle address window. The port bit sends all traffic to an 8-bit port space instead of memory. From these it drives a one-hot set of chip selects, a write enable and a word offset local to the selected region. The selects, the write enable and the offset are combinational, so a synchronous memory can sample them on the same edge.

Each memory and the port space return their read data one clock later on their own data inputs. The decoder remembers which region answered the read and muxes that source onto a single response bus with a valid flag. Accesses that hit no region, and writes aimed at the read-only program store, select nothing. They raise a one-cycle error pulse aligned with the response slot. A read of unmapped space returns zero.

Top module: `bank_port_decoder`

## Requirements
- R1: With the port bit clear, an access to 0x0000..0x7FFF asserts `sel_rom` with `loc_off` = address bits 14:0, and a read returns `rom_rdata`.
- R2: With the port bit clear, an access to 0x8000..0xBFFF asserts `sel_gram` when `cfg_bank` = 0 and `sel_vram` when `cfg_bank` = 1, with `loc_off` = address − 0x8000.
- R3: With the port bit clear, an access to 0xC000..0xFDFF asserts `sel_hram` with `loc_off` = address − 0xC000.
- R4: With the port bit clear, an access to 0xFF00..0xFFFF asserts `sel_stk` with `loc_off` = address − 0xFF00.
- R5: With `cfg_port` = 1, any access asserts only `sel_port`, with `loc_off` = zero-extended address bits 7:0. No memory select is asserted, and no error is raised for any address.
- R6: With the port bit clear, an access to 0xFE00..0xFEFF asserts no select and no write enable, and `err_pulse` is high in the following cycle. A read there gives `rsp_valid` = 1 with `rsp_rdata` = 0x0000.
- R7: A write to 0x0000..0x7FFF with the port bit clear asserts neither `sel_rom` nor `mem_we`, and `err_pulse` is high in the following cycle.
- R8: At most one select is high in any cycle. With neither strobe high, all selects, `mem_we` and `loc_off` are zero.
- R9: A read (`req_rd` = 1, `req_wr` = 0) gives `rsp_valid` = 1 exactly one cycle later, with `rsp_rdata` taken from the region selected in the request cycle. Otherwise `rsp_valid` = 0 and `rsp_rdata` = 0x0000 in the following cycle.
- R10: A change of `cfg_bank` affects only requests issued in the cycle it is applied or later. A read issued before the change still returns data from the bank it selected.
- R11: When both strobes are high, the access is treated as a write: `mem_we` = 1 on a valid target and no response follows.
- R12: After synchronous reset, `rsp_valid` = 0, `err_pulse` = 0 and `rsp_rdata` = 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 16 | Word address of the load/store |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| cfg_bank | input | 1 | Bank bit: 0 general RAM, 1 video RAM in the middle window |
| cfg_port | input | 1 | 1 sends all traffic to the port space |
| rom_rdata | input | 16 | Program store read data (one cycle latency) |
| gram_rdata | input | 16 | Banked general RAM read data |
| vram_rdata | input | 16 | Video RAM read data |
| hram_rdata | input | 16 | Upper general RAM read data |
| stk_rdata | input | 16 | Stack RAM read data |
| port_rdata | input | 16 | Port space read data |
| sel_rom | output | 1 | Program store select |
| sel_gram | output | 1 | Banked general RAM select |
| sel_vram | output | 1 | Video RAM select |
| sel_hram | output | 1 | Upper general RAM select |
| sel_stk | output | 1 | Stack RAM select |
| sel_port | output | 1 | Port space select |
| mem_we | output | 1 | Write enable for the selected target |
| loc_off | output | 15 | Word offset inside the selected region, or port number |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |
| err_pulse | output | 1 | One-cycle error for an unmapped access or a ROM write |

## Verification
The decode is driven with addresses at both ends of every region. Each boundary pair shows whether a comparison is off by one or uses the wrong base for the offset. The banked window is hit with both bank values, and the hole and ROM are written, so the bank steering and the two error causes are seen apart. Port mode is tried on addresses that would otherwise be unmapped or read-only, which proves the redirect overrides the memory map. Back-to-back reads with the bank bit flipped between them show whether the response mux follows the latched region or the live inputs.

// File: rtl/adec_pkg.sv
package adec_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int OFF_W  = 15;
    localparam int PORT_W = 8;
    localparam int N_SRC  = 6;

    localparam logic [ADDR_W-1:0] ROM_LAST  = 16'h7FFF;
    localparam logic [ADDR_W-1:0] WIN_BASE  = 16'h8000;
    localparam logic [ADDR_W-1:0] WIN_LAST  = 16'hBFFF;
    localparam logic [ADDR_W-1:0] HRAM_BASE = 16'hC000;
    localparam logic [ADDR_W-1:0] HRAM_LAST = 16'hFDFF;
    localparam logic [ADDR_W-1:0] STK_BASE  = 16'hFF00;

    // Region code minus one is the bit index of its select and source.
    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_ROM  = 3'd1,
        RG_GRAM = 3'd2,
        RG_VRAM = 3'd3,
        RG_HRAM = 3'd4,
        RG_STK  = 3'd5,
        RG_PORT = 3'd6
    } region_e;

    typedef struct packed {
        region_e          region;
        logic             we;
        logic             rd;
        logic [OFF_W-1:0] off;
        logic             fault;
    } dec_t;

    function automatic region_e map_addr(input logic [ADDR_W-1:0] a, input logic bank);
        region_e r;
        if (a <= ROM_LAST)                           r = RG_ROM;
        else if (a <= WIN_LAST)                      r = bank ? RG_VRAM : RG_GRAM;
        else if (a >= HRAM_BASE && a <= HRAM_LAST)   r = RG_HRAM;
        else if (a >= STK_BASE)                      r = RG_STK;
        else                                         r = RG_NONE;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] region_base(input region_e r);
        logic [ADDR_W-1:0] b;
        case (r)
            RG_GRAM, RG_VRAM: b = WIN_BASE;
            RG_HRAM:          b = HRAM_BASE;
            RG_STK:           b = STK_BASE;
            default:          b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/adec_region_decode.sv
module adec_region_decode
    import adec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              bank,
    input  logic              port,
    output dec_t              dec
);
    region_e           hit;
    logic [ADDR_W-1:0] rel;

    always_comb begin
        hit = map_addr(addr, bank);
        rel = addr - region_base(hit);
    end

    always_comb begin
        dec = '0;
        if (rd || wr) begin
            if (port) begin
                dec.region = RG_PORT;
                dec.off    = OFF_W'(addr[PORT_W-1:0]);
                dec.we     = wr;
                dec.rd     = rd && !wr;
            end else if (hit == RG_NONE || (hit == RG_ROM && wr)) begin
                dec.fault  = 1'b1;
                dec.rd     = rd && !wr;
            end else begin
                dec.region = hit;
                dec.off    = rel[OFF_W-1:0];
                dec.we     = wr;
                dec.rd     = rd && !wr;
            end
        end
    end

    // A fault never carries a target.
    always_comb begin
        if (dec.fault) begin
            AST_FAULT_NO_TARGET: assert (dec.region == RG_NONE && !dec.we); // R6
        end
    end
endmodule

// File: rtl/adec_sel_expand.sv
module adec_sel_expand
    import adec_pkg::*;
(
    input  region_e           region,
    output logic [N_SRC-1:0]  sel
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_sel
        assign sel[g] = (region == region_e'(g + 1));
    end
endmodule

// File: rtl/adec_rsp_stage.sv
module adec_rsp_stage
    import adec_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  region_e                        region,
    input  logic                           is_read,
    input  logic                           fault,
    input  logic [N_SRC-1:0][DATA_W-1:0]   src_rdata,
    output logic                           rsp_valid,
    output logic [DATA_W-1:0]              rsp_rdata,
    output logic                           err_pulse
);
    region_e                          held_q;
    logic                             valid_q;
    logic                             err_q;
    logic [N_SRC-1:0][DATA_W-1:0]     masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= RG_NONE;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            held_q  <= is_read ? region : RG_NONE;
            valid_q <= is_read;
            err_q   <= fault;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_mux
        assign masked[g] = (held_q == region_e'(g + 1)) ? src_rdata[g] : '0;
    end

    always_comb begin
        rsp_rdata = '0;
        for (int i = 0; i < N_SRC; i++) begin
            rsp_rdata = rsp_rdata | masked[i];
        end
    end

    assign rsp_valid = valid_q;
    assign err_pulse = err_q;

    AST_HELD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> held_q == RG_NONE); // R9
endmodule

// File: rtl/bank_port_decoder.sv
module bank_port_decoder
    import adec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              cfg_bank,
    input  logic              cfg_port,
    input  logic [15:0]       rom_rdata,
    input  logic [15:0]       gram_rdata,
    input  logic [15:0]       vram_rdata,
    input  logic [15:0]       hram_rdata,
    input  logic [15:0]       stk_rdata,
    input  logic [15:0]       port_rdata,
    output logic              sel_rom,
    output logic              sel_gram,
    output logic              sel_vram,
    output logic              sel_hram,
    output logic              sel_stk,
    output logic              sel_port,
    output logic              mem_we,
    output logic [14:0]       loc_off,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              err_pulse
);
    dec_t                          dec;
    logic [N_SRC-1:0]              sel;
    logic [N_SRC-1:0][DATA_W-1:0]  src;

    assign src = {port_rdata, stk_rdata, hram_rdata, vram_rdata, gram_rdata, rom_rdata};

    adec_region_decode u_decode (
        .addr (req_addr),
        .rd   (req_rd),
        .wr   (req_wr),
        .bank (cfg_bank),
        .port (cfg_port),
        .dec  (dec)
    );

    adec_sel_expand u_sel (
        .region (dec.region),
        .sel    (sel)
    );

    adec_rsp_stage u_rsp (
        .clk       (clk),
        .rst       (rst),
        .region    (dec.region),
        .is_read   (dec.rd),
        .fault     (dec.fault),
        .src_rdata (src),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .err_pulse (err_pulse)
    );

    assign {sel_port, sel_stk, sel_hram, sel_vram, sel_gram, sel_rom} = sel;
    assign mem_we  = dec.we;
    assign loc_off = dec.off;

    logic access, mem_mode, in_hole, rom_wr, rd_only;
    assign access   = req_rd || req_wr;
    assign mem_mode = access && !cfg_port;
    assign in_hole  = req_addr[15:8] == 8'hFE;
    assign rom_wr   = req_wr && !cfg_port && !req_addr[15];
    assign rd_only  = req_rd && !req_wr;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_rom, sel_gram, sel_vram, sel_hram, sel_stk, sel_port})); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !access |-> !mem_we && loc_off == '0 && !(sel_rom || sel_gram || sel_vram || sel_hram || sel_stk || sel_port)); // R8
    AST_PORT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (access && cfg_port) |-> sel_port); // R5
    AST_WINDOW_BANK: assert property (@(posedge clk) disable iff (rst)
        (mem_mode && req_addr[15:14] == 2'b10) |-> (cfg_bank ? sel_vram : sel_gram)); // R2
    AST_HOLE_ERR: assert property (@(posedge clk) disable iff (rst)
        (mem_mode && in_hole) |=> err_pulse); // R6
    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_mode && in_hole && rd_only) |=> (rsp_valid && rsp_rdata == '0)); // R6
    AST_ROM_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        rom_wr |-> (!mem_we && !sel_rom)); // R7
    AST_ROM_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
        rom_wr |=> err_pulse); // R7
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        rd_only |=> rsp_valid); // R9
    AST_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        !rd_only |=> (!rsp_valid && rsp_rdata == '0)); // R9
    AST_DUAL_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_wr && (sel_gram || sel_hram || sel_stk || sel_port)) |-> mem_we); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && !err_pulse)); // R12
endmodule

// File: tb/bank_port_decoder_tb.sv
module bank_port_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] req_addr;
    logic        req_rd, req_wr, cfg_bank, cfg_port;
    logic        sel_rom, sel_gram, sel_vram, sel_hram, sel_stk, sel_port;
    logic        mem_we, rsp_valid, err_pulse;
    logic [14:0] loc_off;
    logic [15:0] rsp_rdata;

    localparam logic [15:0] D_ROM  = 16'hA001;
    localparam logic [15:0] D_GRAM = 16'hB002;
    localparam logic [15:0] D_VRAM = 16'hC003;
    localparam logic [15:0] D_HRAM = 16'hD004;
    localparam logic [15:0] D_STK  = 16'hE005;
    localparam logic [15:0] D_PORT = 16'hF006;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    bank_port_decoder u_dut (
        .clk(clk), .rst(rst), .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
        .cfg_bank(cfg_bank), .cfg_port(cfg_port),
        .rom_rdata(D_ROM), .gram_rdata(D_GRAM), .vram_rdata(D_VRAM),
        .hram_rdata(D_HRAM), .stk_rdata(D_STK), .port_rdata(D_PORT),
        .sel_rom(sel_rom), .sel_gram(sel_gram), .sel_vram(sel_vram), .sel_hram(sel_hram),
        .sel_stk(sel_stk), .sel_port(sel_port), .mem_we(mem_we), .loc_off(loc_off),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse)
    );

    // {req, addr, rd, wr, bank, port, sel[rom,gram,vram,hram,stk,port], we, off, err, rdata}
    localparam int NV = 18;
    localparam logic [62:0] VEC [NV] = '{
        {4'd1,  16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100000, 1'b0, 15'h0000, 1'b0, D_ROM},  // R1
        {4'd1,  16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b0, 6'b100000, 1'b0, 15'h7FFF, 1'b0, D_ROM},  // R1
        {4'd2,  16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010000, 1'b0, 15'h0000, 1'b0, D_GRAM}, // R2
        {4'd2,  16'hBFFF, 1'b1, 1'b0, 1'b1, 1'b0, 6'b001000, 1'b0, 15'h3FFF, 1'b0, D_VRAM}, // R2
        {4'd2,  16'h8123, 1'b0, 1'b1, 1'b1, 1'b0, 6'b001000, 1'b1, 15'h0123, 1'b0, 16'h0},  // R2
        {4'd3,  16'hC000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000100, 1'b0, 15'h0000, 1'b0, D_HRAM}, // R3
        {4'd3,  16'hFDFF, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000100, 1'b1, 15'h3DFF, 1'b0, 16'h0},  // R3
        {4'd3,  16'hFDFF, 1'b1, 1'b0, 1'b1, 1'b0, 6'b000100, 1'b0, 15'h3DFF, 1'b0, D_HRAM}, // R3
        {4'd6,  16'hFE00, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 15'h0000, 1'b1, 16'h0},  // R6
        {4'd6,  16'hFEFF, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 15'h0000, 1'b1, 16'h0},  // R6
        {4'd4,  16'hFF00, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000010, 1'b0, 15'h0000, 1'b0, D_STK},  // R4
        {4'd4,  16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000010, 1'b1, 15'h00FF, 1'b0, 16'h0},  // R4
        {4'd7,  16'h1234, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 15'h0000, 1'b1, 16'h0},  // R7
        {4'd5,  16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000001, 1'b0, 15'h0034, 1'b0, D_PORT}, // R5
        {4'd5,  16'hFE80, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000001, 1'b1, 15'h0080, 1'b0, 16'h0},  // R5
        {4'd11, 16'h9000, 1'b1, 1'b1, 1'b0, 1'b0, 6'b010000, 1'b1, 15'h1000, 1'b0, 16'h0},  // R11
        {4'd11, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 15'h0000, 1'b1, 16'h0},  // R11 with R7
        {4'd8,  16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 15'h0000, 1'b0, 16'h0}   // R8
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic b, input logic p);
        req_addr = a; req_rd = rd; req_wr = wr; cfg_bank = b; cfg_port = p;
    endtask

    function automatic logic [5:0] sels();
        return {sel_rom, sel_gram, sel_vram, sel_hram, sel_stk, sel_port};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check(12, "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        check(12, "err_pulse in reset", {31'b0, err_pulse}, 32'd0);
        check(12, "rsp_rdata in reset", {16'b0, rsp_rdata}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            int          rq;
            logic [62:0] v;
            logic        erd;
            v   = VEC[i];
            rq  = int'(v[62:59]);
            erd = v[42] && !v[41];
            drive(v[58:43], v[42], v[41], v[40], v[39]);
            #1;
            check(rq, $sformatf("selects @%h", v[58:43]), {26'b0, sels()}, {26'b0, v[38:33]});
            check(rq, $sformatf("mem_we @%h", v[58:43]), {31'b0, mem_we}, {31'b0, v[32]});
            check(rq, $sformatf("loc_off @%h", v[58:43]), {17'b0, loc_off}, {17'b0, v[31:17]});
            @(negedge clk);
            drive(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
            #1;
            check(rq, $sformatf("err_pulse after @%h", v[58:43]), {31'b0, err_pulse}, {31'b0, v[16]});
            check(9,  $sformatf("rsp_valid after @%h", v[58:43]), {31'b0, rsp_valid}, {31'b0, erd});
            check(rq, $sformatf("rsp_rdata after @%h", v[58:43]), {16'b0, rsp_rdata}, {16'b0, v[15:0]});
            @(negedge clk);
        end

        // R10: back-to-back reads of one window address, bank flipped between them
        drive(16'h8040, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(16'h8040, 1'b1, 1'b0, 1'b1, 1'b0);
        #1;
        check(10, "vram selected after bank flip", {31'b0, sel_vram}, 32'd1);
        check(10, "first response from general RAM", {16'b0, rsp_rdata}, {16'b0, D_GRAM});
        @(negedge clk);
        drive(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check(10, "second response from video RAM", {16'b0, rsp_rdata}, {16'b0, D_VRAM});
        check(9,  "second response valid", {31'b0, rsp_valid}, 32'd1);
        @(negedge clk);

        // R10: bank flips back during the response cycle of a video read
        drive(16'hA000, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        drive(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check(10, "response keeps latched bank", {16'b0, rsp_rdata}, {16'b0, D_VRAM});
        @(negedge clk);
        #1;
        check(9, "idle cycle gives no response", {31'b0, rsp_valid}, 32'd0);
        check(9, "idle cycle data zero", {16'b0, rsp_rdata}, 32'd0);

        // R6 then R4 back to back: error only in the first response slot
        @(negedge clk);
        drive(16'hFE10, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(16'hFF10, 1'b1, 1'b0, 1'b0, 1'b0);
        #1;
        check(6, "hole read error", {31'b0, err_pulse}, 32'd1);
        check(6, "hole read data zero", {16'b0, rsp_rdata}, 32'd0);
        check(4, "stack offset", {17'b0, loc_off}, 32'h10);
        @(negedge clk);
        drive(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check(6, "error is one cycle only", {31'b0, err_pulse}, 32'd0);
        check(4, "stack read data", {16'b0, rsp_rdata}, {16'b0, D_STK});

        // R12: reset mid-response
        @(negedge clk);
        drive(16'h0010, 1'b1, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(12, "reset clears response", {31'b0, rsp_valid}, 32'd0);
        check(12, "reset clears data", {16'b0, rsp_rdata}, 32'd0);
        rst = 1'b0;
        drive(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule